// File: doc/BRIEF.md
# Host I/O Debug Port Capture

This block watches host I/O write cycles for debug progress codes and keeps them in a small capture queue for firmware to drain. A write hits the main window when its dword address matches a fixed 4-byte aligned base, and it may enable 1, 2 or 4 byte lanes. A second, optional single-byte alias address can also be watched. Every captured write is broken into one queue entry per written byte. Each entry holds the data byte, the lane the byte came from and a code for the size of the host cycle.

Firmware sets up the block through a configuration register. It learns the queue state from a three-bit status word and drains the queue through a 32-bit read word. The read word holds the head entry together with live copies of the status flags. An interrupt output rises when the fill level reaches a selectable threshold and the interrupt is enabled.

Top module: `dbg_port_capture`

## Requirements
- R1: After reset the queue is empty, the status word is 0, irq is 0 and the configuration reads back as 0.
- R2: When the main window is active (config bit 12), a write whose dword address matches the window base and has any byte enable set pushes one entry per enabled lane, lowest lane first. Each entry holds the byte in entry bits [7:0], the lane number in [9:8] and the size code in [11:10]: 0 for a single lane, 1 for lane pairs 0011 or 1100, 2 for 1111.
- R3: Any other non-zero byte-enable pattern on a main window write is captured lane by lane with size code 3.
- R4: An alias write is a write to the alias dword with exactly the alias address's byte enable. When both config bits 5 and 13 are set, an alias write pushes one entry with size 0 and the lane taken from config bits [7:6]. A main window write is ignored when bit 12 is clear, and an alias write is ignored when bit 5 or bit 13 is clear. Multi-byte writes to the alias address are ignored.
- R5: A write whose byte count exceeds the free space is dropped as a whole and sets the sticky overrun flag (status bit 1). The flag is cleared by a status write with bit 1 set. If a new overrun happens in the same cycle as a clear, the flag stays set.
- R6: The read word carries the head entry in bits [11:0], not-empty in bit 12, overrun in bit 13 and threshold in bit 14. Bits [31:15] are zero. When the queue is empty, bits [11:0] read as zero.
- R7: A read strobe pops one entry when the queue is not empty. A read strobe on an empty queue changes nothing. Status bit 0 shows not-empty.
- R8: Status bit 2 is set while the entry count is at least the level selected by config bits [2:0]. Codes 0 to 7 select the levels 1, 4, 8, 16, 20, 24, 28 and 30.
- R9: irq equals status bit 2 AND config bit 4.
- R10: Only config bits [2:0], [7:4] and [13:12] are stored. All other bits read back as 0.
- R11: The queue holds 32 entries. It accepts exactly 32 bytes before the next write overruns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host I/O write strobe, one cycle per write |
| host_addr | input | ADDR_W | Host I/O byte address; bits [1:0] are ignored |
| host_be | input | 4 | Host byte enables, one per lane |
| host_wdata | input | 32 | Host write data, lane n in bits [8n+7:8n] |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Configuration readback |
| sts_wr | input | 1 | Status write strobe (write 1 to clear) |
| sts_wdata | input | 3 | Status write value; bit 1 clears overrun |
| sts | output | 3 | {threshold, overrun, not-empty} |
| fifo_rd | input | 1 | Read strobe, pops the head entry |
| rd_word | output | 32 | Head entry with live status copies |
| irq | output | 1 | Threshold interrupt |

## Verification
The assertions check several rules on every cycle. The fill count never exceeds the depth. A blocked write leaves the count alone, and so does a pop on an empty queue. Overrun rises only after a blocked write and holds until it is cleared. Threshold implies not-empty. A main window hit pushes exactly as many entries as it has enabled lanes, and an alias hit pushes exactly one. Other behaviour needs the bench's scenarios: the lane order inside the queue, the size codes, the alias lane remapping, the drop-whole-write rule at the 32-entry boundary and each threshold level. The bench checks these against a reference queue kept in the bench.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  // One queued byte: size code, source lane, data.
  typedef struct packed {
    logic [1:0] size;
    logic [1:0] lane;
    logic [7:0] data;
  } dpc_entry_t;

  localparam int LANES = 4;

  // Size code of a host cycle from its byte enables.
  function automatic logic [1:0] be_size_code(input logic [3:0] be);
    case (be)
      4'b0001, 4'b0010, 4'b0100, 4'b1000: return 2'd0;
      4'b0011, 4'b1100:                   return 2'd1;
      4'b1111:                            return 2'd2;
      default:                            return 2'd3;
    endcase
  endfunction

  // Fill level selected by the threshold code.
  function automatic logic [5:0] thr_level(input logic [2:0] code);
    case (code)
      3'd0: return 6'd1;
      3'd1: return 6'd4;
      3'd2: return 6'd8;
      3'd3: return 6'd16;
      3'd4: return 6'd20;
      3'd5: return 6'd24;
      3'd6: return 6'd28;
      default: return 6'd30;
    endcase
  endfunction

endpackage

// File: rtl/dpc_decode.sv
module dpc_decode
  import dpc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h0080,
  parameter logic [ADDR_W-1:0] ALIAS_ADDR = 16'h0091
) (
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [3:0]        host_be,
  input  logic [31:0]       host_wdata,
  input  logic              main_act,
  input  logic              alias_on,
  input  logic [1:0]        alias_lane,
  output dpc_entry_t [LANES-1:0] ent,
  output logic [2:0]        n_push,
  output logic              main_hit,
  output logic              alias_hit
);
  localparam logic [1:0] AL_IN = ALIAS_ADDR[1:0];
  localparam logic [3:0] AL_BE = 4'b0001 << AL_IN;

  logic main_word, alias_word;
  logic [1:0] sz;

  assign main_word  = host_addr[ADDR_W-1:2] == WIN_BASE[ADDR_W-1:2];
  assign alias_word = host_addr[ADDR_W-1:2] == ALIAS_ADDR[ADDR_W-1:2];
  assign main_hit   = host_wr && main_act && main_word && (host_be != 4'b0000);
  assign alias_hit  = host_wr && alias_on && !main_hit && alias_word && (host_be == AL_BE);
  assign sz         = be_size_code(host_be);

  // Compact enabled lanes into consecutive slots, lowest lane first.
  always_comb begin
    ent    = '0;
    n_push = 3'd0;
    if (main_hit) begin
      for (int i = 0; i < LANES; i++) begin
        if (host_be[i]) begin
          ent[n_push[1:0]] = '{size: sz, lane: 2'(i), data: host_wdata[8*i +: 8]};
          n_push = n_push + 3'd1;
        end
      end
    end else if (alias_hit) begin
      ent[0] = '{size: 2'd0, lane: alias_lane, data: host_wdata[8*int'(AL_IN) +: 8]};
      n_push = 3'd1;
    end
  end
endmodule

// File: rtl/dpc_fifo.sv
module dpc_fifo
  import dpc_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                push_n,
  input  dpc_entry_t [LANES-1:0]    push_ent,
  input  logic                      pop_req,
  output dpc_entry_t                head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                      accept,
  output logic                      blocked,
  output logic                      pop_en
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  dpc_entry_t mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] free;

  assign free    = CNT_W'(DEPTH) - count;
  assign accept  = (push_n != 3'd0) && (CNT_W'(push_n) <= free);
  assign blocked = (push_n != 3'd0) && !accept;
  assign pop_en  = pop_req && (count != '0);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int i = 0; i < LANES; i++) begin
        if (3'(i) < push_n) mem[wr_ptr + PTR_W'(i)] <= push_ent[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept) wr_ptr <= wr_ptr + PTR_W'(push_n);
      if (pop_en) rd_ptr <= rd_ptr + PTR_W'(1);
      count <= count + (accept ? CNT_W'(push_n) : CNT_W'(0)) - (pop_en ? CNT_W'(1) : CNT_W'(0));
    end
  end

  // R11: fill count never passes the depth
  a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R5: a dropped write adds nothing to the queue
  a_r5_drop_whole: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && !pop_req) |=> count == $past(count));
  // R7: a read on an empty queue leaves it empty
  a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && pop_req && push_n == 3'd0) |=> count == '0);
endmodule

// File: rtl/dbg_port_capture.sv
module dbg_port_capture
  import dpc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h0080,
  parameter logic [ADDR_W-1:0] ALIAS_ADDR = 16'h0091,
  parameter int DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [3:0]        host_be,
  input  logic [31:0]       host_wdata,
  input  logic              cfg_wr,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              sts_wr,
  input  logic [2:0]        sts_wdata,
  output logic [2:0]        sts,
  input  logic              fifo_rd,
  output logic [31:0]       rd_word,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH+1);

  // configuration fields
  logic [2:0] thr_code;
  logic       thr_ien, alias_en, main_act, alias_act;
  logic [1:0] alias_lane;
  logic       ovr_q;

  // internal events brought out for the assertions
  dpc_entry_t [LANES-1:0] ent;
  dpc_entry_t head;
  logic [2:0] n_push;
  logic main_hit, alias_hit, accept, blocked, pop_en;
  logic [CNT_W-1:0] count;
  logic ne, thr, ovr_clr;

  dpc_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .ALIAS_ADDR(ALIAS_ADDR)) u_decode (
    .host_wr(host_wr), .host_addr(host_addr), .host_be(host_be), .host_wdata(host_wdata),
    .main_act(main_act), .alias_on(alias_en && alias_act), .alias_lane(alias_lane),
    .ent(ent), .n_push(n_push), .main_hit(main_hit), .alias_hit(alias_hit)
  );

  dpc_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_n(n_push), .push_ent(ent), .pop_req(fifo_rd),
    .head(head), .count(count), .accept(accept), .blocked(blocked), .pop_en(pop_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_code   <= '0;
      thr_ien    <= 1'b0;
      alias_en   <= 1'b0;
      alias_lane <= '0;
      main_act   <= 1'b0;
      alias_act  <= 1'b0;
    end else if (cfg_wr) begin
      thr_code   <= cfg_wdata[2:0];
      thr_ien    <= cfg_wdata[4];
      alias_en   <= cfg_wdata[5];
      alias_lane <= cfg_wdata[7:6];
      main_act   <= cfg_wdata[12];
      alias_act  <= cfg_wdata[13];
    end
  end

  assign ovr_clr = sts_wr && sts_wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n)       ovr_q <= 1'b0;
    else if (blocked) ovr_q <= 1'b1;
    else if (ovr_clr) ovr_q <= 1'b0;
  end

  assign ne  = count != '0;
  assign thr = 32'(count) >= 32'(thr_level(thr_code));
  assign sts = {thr, ovr_q, ne};
  assign irq = thr && thr_ien;

  assign cfg_rdata = {2'b00, alias_act, main_act, 4'b0000,
                      alias_lane, alias_en, thr_ien, 1'b0, thr_code};
  assign rd_word   = {16'h0000, 1'b0, thr, ovr_q, ne, ne ? 12'(head) : 12'h000};

  // R5: overrun only rises after a blocked write
  a_r5_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(blocked));
  // R5: overrun holds until a clear request
  a_r5_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !ovr_clr) |=> ovr_q);
  // R8: a threshold hit implies data present
  a_r8_thr_ne: assert property (@(posedge clk) disable iff (!rst_n)
    thr |-> ne);
  // R2: one entry per enabled lane on a window hit
  a_r2_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
    main_hit |-> 32'(n_push) == $countones(host_be));
  // R4: an alias hit is always a single byte and never a window hit
  a_r4_alias_one: assert property (@(posedge clk) disable iff (!rst_n)
    alias_hit |-> (n_push == 3'd1 && !main_hit));
  // R9: interrupt only with enable
  a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (thr_ien && sts[2]));
endmodule

// File: tb/dbg_port_capture_bench.sv
module dbg_port_capture_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] WIN   = 16'h0080;
  localparam logic [15:0] ALIAS = 16'h0091;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 1'b0;
  logic [15:0] host_addr = '0;
  logic [3:0] host_be = '0;
  logic [31:0] host_wdata = '0;
  logic cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic sts_wr = 1'b0;
  logic [2:0] sts_wdata = '0;
  logic [2:0] sts;
  logic fifo_rd = 1'b0;
  logic [31:0] rd_word;
  logic irq;

  dbg_port_capture #(.ADDR_W(16), .WIN_BASE(WIN), .ALIAS_ADDR(ALIAS), .DEPTH(32)) u_dbg_port_capture (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr), .host_be(host_be),
    .host_wdata(host_wdata), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .sts(sts), .fifo_rd(fifo_rd), .rd_word(rd_word), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [15:0] mcfg = '0;
  logic movr = 1'b0;
  logic [11:0] mq[$];

  function automatic int lvl(input logic [2:0] c);
    if (c == 3'd0) return 1;
    if (c < 3'd4) return 4 << (c - 1);
    if (c == 3'd7) return 30;
    return 16 + 4 * (int'(c) - 3);
  endfunction

  function automatic logic [1:0] szc(input logic [3:0] be);
    int ones = 0;
    for (int k = 0; k < 4; k++) ones += int'(be[k]);
    if (ones == 1) return 2'd0;
    if (be == 4'h3 || be == 4'hC) return 2'd1;
    if (be == 4'hF) return 2'd2;
    return 2'd3;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    logic ne, thr;
    ne  = mq.size() != 0;
    thr = int'(mq.size()) >= lvl(mcfg[2:0]);
    chk({tag, " R7/R8 status"}, 32'(sts), 32'({thr, movr, ne}));
    chk({tag, " R9 irq"}, 32'(irq), 32'(thr && mcfg[4]));
    chk({tag, " R6 read word"}, rd_word,
        {17'h0, thr, movr, ne, ne ? mq[0] : 12'h000});
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hwrite(input logic [15:0] a, input logic [3:0] be, input logic [31:0] d);
    logic [11:0] e[4];
    int n = 0;
    logic mh, ah;
    host_wr = 1'b1; host_addr = a; host_be = be; host_wdata = d;
    step();
    host_wr = 1'b0;
    mh = mcfg[12] && a[15:2] == WIN[15:2] && be != 4'h0;
    ah = !mh && mcfg[5] && mcfg[13] && a[15:2] == ALIAS[15:2] && be == (4'b0001 << ALIAS[1:0]);
    if (mh) begin
      for (int l = 0; l < 4; l++)
        if (be[l]) begin e[n] = {szc(be), 2'(l), d[8*l +: 8]}; n++; end
    end else if (ah) begin
      e[0] = {2'b00, mcfg[7:6], d[8*int'(ALIAS[1:0]) +: 8]};
      n = 1;
    end
    if (n > 0) begin
      if (n > 32 - int'(mq.size())) movr = 1'b1;
      else for (int j = 0; j < n; j++) mq.push_back(e[j]);
    end
  endtask

  task automatic cfgw(input logic [15:0] d);
    cfg_wr = 1'b1; cfg_wdata = d;
    step();
    cfg_wr = 1'b0;
    mcfg = d & 16'h30F7;
  endtask

  task automatic clr(input logic [2:0] d);
    sts_wr = 1'b1; sts_wdata = d;
    step();
    sts_wr = 1'b0;
    if (d[1]) movr = 1'b0;
  endtask

  task automatic rd();
    fifo_rd = 1'b1;
    step();
    fifo_rd = 1'b0;
    if (mq.size() > 0) void'(mq.pop_front());
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 status", 32'(sts), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 read word", rd_word, 32'h0);
    chk("R1 config", 32'(cfg_rdata), 32'h0);

    // R10 readback mask
    cfgw(16'hFFFF);
    chk("R10 config mask", 32'(cfg_rdata), 32'h30F7);

    // R2 four byte write, lanes in order
    cfgw(16'h30B0);
    hwrite(WIN, 4'hF, 32'h44332211);
    chk("R2 head full write", rd_word, 32'h00005811);
    for (int i = 0; i < 4; i++) begin chk_all("R2 lane order"); rd(); end
    hwrite(WIN + 16'd2, 4'hC, 32'hBBAA0000);
    chk("R2 upper pair", rd_word, 32'h000056AA);
    rd(); rd();
    // R3 odd pattern
    hwrite(WIN, 4'h5, 32'h00CC00DD);
    chk("R3 size invalid", rd_word, 32'h00005CDD);
    rd(); chk_all("R3 second byte"); rd();
    // R4 alias remap to lane 2
    hwrite(ALIAS, 4'h2, 32'h0000AB00);
    chk("R4 alias entry", rd_word, 32'h000052AB);
    rd();
    hwrite(ALIAS, 4'h6, 32'h00ABAB00);
    chk("R4 alias multi-byte ignored", rd_word, 32'h0);
    cfgw(16'h20B0);
    hwrite(WIN, 4'h1, 32'h55);
    chk("R4 inactive window ignored", rd_word, 32'h0);
    cfgw(16'h10B0);
    hwrite(ALIAS, 4'h2, 32'h0000AB00);
    chk("R4 inactive alias ignored", rd_word, 32'h0);

    // R11 / R5 fill to capacity then overrun
    cfgw(16'h3017);
    for (int i = 0; i < 8; i++) begin
      hwrite(WIN, 4'hF, $urandom);
      chk_all("R11 fill");
    end
    hwrite(WIN, 4'h1, 32'h77);
    chk_all("R5 overrun drop");
    chk("R5 overrun flag", 32'(sts[1]), 32'h1);
    for (int i = 0; i < 32; i++) begin rd(); chk_all("R11 drain"); end
    rd();
    chk_all("R7 empty read");
    clr(3'b010);
    chk_all("R5 clear");
    chk("R5 cleared", 32'(sts[1]), 32'h0);
    // R5 partial fit still drops whole write
    for (int i = 0; i < 30; i++) hwrite(WIN, 4'h1, 32'(i));
    hwrite(WIN, 4'hF, 32'hDEADBEEF);
    chk_all("R5 partial drop");
    while (mq.size() > 0) rd();
    clr(3'b111);
    chk_all("R5 empty after clear");

    // R8 threshold sweep
    for (int c = 0; c < 8; c++) begin
      cfgw(16'h3010 | 16'(c));
      for (int i = 0; i < 32; i++) begin hwrite(WIN, 4'h1, 32'(i)); chk_all("R8 sweep fill"); end
      for (int i = 0; i < 32; i++) begin rd(); chk_all("R8 sweep drain"); end
    end

    // random mix
    cfgw(16'h30F3);
    for (int i = 0; i < 800; i++) begin
      int k, s;
      logic [15:0] a;
      logic [3:0] be;
      k = $urandom_range(0, 11);
      if (k <= 5) begin
        s = $urandom_range(0, 2);
        a = (s == 0) ? (WIN | 16'($urandom_range(0, 3))) : (s == 1) ? ALIAS : 16'h00A4;
        be = 4'($urandom_range(0, 15));
        if (s == 1 && $urandom_range(0, 1) == 1) be = 4'h2;
        hwrite(a, be, $urandom);
      end else if (k <= 9) rd();
      else if (k == 10) clr(3'($urandom));
      else cfgw(16'($urandom) | 16'h3000);
      chk_all("R2/R5 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule